// File: doc/BRIEF.md
# Digital Frequency-Matching Loop Controller

This block closes a fully digital frequency loop around a ring-type oscillator with nine speed settings. It brings in the raw oscillator and reference waveforms, resynchronises both to the system clock and divides the oscillator by N and the reference by M. It then counts divided-oscillator edges over a fixed window of divided-reference periods and turns each window into a single verdict: the oscillator is either running fast or running slow. The target frequency is the reference frequency times N/M.

The speed code starts at the fastest setting, 8, and steps down one setting per verdict. The first slow verdict reverses the direction and marks acquisition. From then on the code steps one setting per verdict, toward the target, so it dithers between the two settings that straddle the target. A run of alternating verdicts raises a lock flag, and two verdicts in the same direction drop it. Once acquisition is reached, a bang-bang phase comparator issues one-cycle advance or recede requests for a downstream phase stage.

The controller has three states. ST_SWEEP takes the sweep step (a fast verdict lowers the code). The reversal moves ST_SWEEP to ST_COARSE. In ST_COARSE an alternation counter counts verdicts whose direction differs from the one before, and reaching the count takes the lock entry to ST_LOCK. From ST_LOCK a repeated direction takes the unlock back to ST_COARSE. A restart, caused by reset or a load pulse, returns every state to ST_SWEEP at the fastest code.

Top module: `fml_loop_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycles after it, code_o is 8 (the fastest of the settings 0..8), and acq_o, lock_o, adv_o and rec_o are low.
- R2: While acq_o is low, every fast verdict lowers code_o by exactly one, and code_o never rises.
- R3: The first slow verdict while acq_o is low raises code_o by one and sets acq_o in the same cycle.
- R4: While acq_o is high, each verdict moves code_o by one: down on fast and up on slow. In steady state code_o alternates between the two adjacent settings that bracket the target.
- R5: lock_o rises on the fourth consecutive verdict after acquisition whose direction differs from the one before it. That is the fourth code change after acq_o rises.
- R6: While locked, two consecutive verdicts in the same direction drop lock_o while acq_o stays high, and lock is regained later at the new bracket.
- R7: A verdict is fast when more than WIN divided-oscillator edges occur within WIN divided-reference periods, and slow otherwise. The target is therefore f_ref*N/M, with N on fb_div_i and M on ref_div_i.
- R8: A one-cycle load_i pulse samples fb_div_i and ref_div_i. By the next cycle it has set code_o to 8, cleared acq_o and lock_o, and restarted measurement. The first cycle after reset samples the ratios in the same way.
- R9: Changes on fb_div_i and ref_div_i without a load pulse have no effect on code_o or lock_o.
- R10: code_o saturates at 0 when every verdict is fast. In that case acq_o stays low.
- R11: A slow verdict at code 8 leaves code_o at 8 (saturation) and still sets acq_o. Repeated slow verdicts never raise lock_o.
- R12: adv_o and rec_o are single-cycle pulses that are never high together. They occur only when acq_o was high in the previous cycle. On each divided-reference edge one of them fires: rec_o if a divided-oscillator edge came since the previous divided-reference edge, adv_o if none came, and neither if both edges coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both sensed waveforms |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Raw oscillator waveform, asynchronous |
| ref_in | input | 1 | Raw reference waveform, asynchronous |
| fb_div_i | input | DIV_W | Feedback divide ratio N |
| ref_div_i | input | DIV_W | Reference divide ratio M |
| load_i | input | 1 | Samples the ratios and restarts acquisition |
| code_o | output | CODE_W | Oscillator speed code, 8 fastest |
| acq_o | output | 1 | Frequency acquired (coarse lock reached) |
| lock_o | output | 1 | Dithering lock flag |
| adv_o | output | 1 | Phase advance request pulse |
| rec_o | output | 1 | Phase recede request pulse |

## Verification
A verdict leaves the meter one cycle after the closing divided-reference edge, and code_o, acq_o and lock_o move on the following edge. Window length depends on the modelled oscillator, so the bench waits for these outputs with bounded deadlines at falling edges and checks the value present when the change is seen. A load or reset takes effect through a single register, so it is checked at the first falling edge after the pulse. Phase pulses are sampled at every falling edge and judged against the acq_o value sampled one edge earlier.

// File: rtl/fml_pkg.sv
package fml_pkg;

    typedef enum logic [1:0] {
        ST_SWEEP  = 2'd0,
        ST_COARSE = 2'd1,
        ST_LOCK   = 2'd2
    } fml_state_e;

    typedef enum logic {
        DIR_SLOW = 1'b0,
        DIR_FAST = 1'b1
    } fml_dir_e;

endpackage

// File: rtl/fml_edge_sync.sv
module fml_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // STAGES flops for metastability settling, one more for the edge compare
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], din};
        end
    end

    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/fml_divider.sv
module fml_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] ratio,
    input  logic         tick_in,
    output logic         tick_out
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] term;

    // a ratio of zero behaves as divide-by-one
    always_comb begin
        term = (ratio == '0) ? '0 : ratio - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            tick_out <= 1'b0;
        end else if (clr) begin
            cnt_q    <= '0;
            tick_out <= 1'b0;
        end else begin
            tick_out <= 1'b0;
            if (tick_in) begin
                if (cnt_q >= term) begin
                    cnt_q    <= '0;
                    tick_out <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fml_freq_meter.sv
module fml_freq_meter #(
    parameter int WIN   = 32,
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ref_tick,
    input  logic osc_tick,
    output logic meas_valid,
    output logic meas_fast
);
    localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN - 1);
    localparam logic [CNT_W-1:0] WIN_CNT  = CNT_W'(WIN);

    logic             armed_q;
    logic [WIN_W-1:0] ref_cnt_q;
    logic [CNT_W-1:0] osc_cnt_q;
    logic [CNT_W-1:0] osc_inc;

    // saturating edge count including an edge in this very cycle
    always_comb begin
        osc_inc = (osc_tick && osc_cnt_q != '1) ? osc_cnt_q + 1'b1 : osc_cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            ref_cnt_q  <= '0;
            osc_cnt_q  <= '0;
            meas_valid <= 1'b0;
            meas_fast  <= 1'b0;
        end else if (clr) begin
            armed_q    <= 1'b0;
            ref_cnt_q  <= '0;
            osc_cnt_q  <= '0;
            meas_valid <= 1'b0;
            meas_fast  <= 1'b0;
        end else begin
            meas_valid <= 1'b0;
            if (!armed_q) begin
                // first divided reference edge opens the first window
                if (ref_tick) begin
                    armed_q   <= 1'b1;
                    ref_cnt_q <= '0;
                    osc_cnt_q <= '0;
                end
            end else if (ref_tick && ref_cnt_q == WIN_LAST) begin
                meas_valid <= 1'b1;
                meas_fast  <= (osc_inc > WIN_CNT);
                ref_cnt_q  <= '0;
                osc_cnt_q  <= '0;
            end else begin
                osc_cnt_q <= osc_inc;
                if (ref_tick) begin
                    ref_cnt_q <= ref_cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fml_phase_det.sv
module fml_phase_det (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ref_tick,
    input  logic osc_tick,
    output logic adv,
    output logic rec
);
    logic osc_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_seen_q <= 1'b0;
            adv        <= 1'b0;
            rec        <= 1'b0;
        end else if (!en) begin
            osc_seen_q <= 1'b0;
            adv        <= 1'b0;
            rec        <= 1'b0;
        end else begin
            adv <= 1'b0;
            rec <= 1'b0;
            if (ref_tick) begin
                if (!osc_tick) begin
                    // oscillator edge already seen: it leads, hold it back
                    rec <= osc_seen_q;
                    adv <= ~osc_seen_q;
                end
                osc_seen_q <= 1'b0;
            end else if (osc_tick) begin
                osc_seen_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fml_loop_ctrl.sv
module fml_loop_ctrl
    import fml_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int CODE_MAX    = 8,
    parameter int WIN         = 32,
    parameter int LOCK_ALT    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CODE_W      = $clog2(CODE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_in,
    input  logic              ref_in,
    input  logic [DIV_W-1:0]  fb_div_i,
    input  logic [DIV_W-1:0]  ref_div_i,
    input  logic              load_i,
    output logic [CODE_W-1:0] code_o,
    output logic              acq_o,
    output logic              lock_o,
    output logic              adv_o,
    output logic              rec_o
);
    localparam int CNT_W = $clog2(WIN) + 3;
    localparam int ALT_W = $clog2(LOCK_ALT + 1);
    localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(CODE_MAX);
    localparam logic [ALT_W-1:0]  ALT_LAST = ALT_W'(LOCK_ALT - 1);
    localparam int NCH = 2;   // channel 0: reference, channel 1: oscillator

    // ratio capture and restart
    logic             init_q;
    logic             restart;
    logic [DIV_W-1:0] fb_ratio_q;
    logic [DIV_W-1:0] ref_ratio_q;

    assign restart = load_i | ~init_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q      <= 1'b0;
            fb_ratio_q  <= DIV_W'(1);
            ref_ratio_q <= DIV_W'(1);
        end else begin
            init_q <= 1'b1;
            if (restart) begin
                fb_ratio_q  <= fb_div_i;
                ref_ratio_q <= ref_div_i;
            end
        end
    end

    // synchronise and divide both waveforms
    logic             raw_in   [NCH];
    logic [DIV_W-1:0] ch_ratio [NCH];
    logic             ch_rise  [NCH];
    logic             ch_tick  [NCH];

    assign raw_in[0]   = ref_in;
    assign raw_in[1]   = osc_in;
    assign ch_ratio[0] = ref_ratio_q;
    assign ch_ratio[1] = fb_ratio_q;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        fml_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (ch_rise[g])
        );

        fml_divider #(
            .W(DIV_W)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (restart),
            .ratio   (ch_ratio[g]),
            .tick_in (ch_rise[g]),
            .tick_out(ch_tick[g])
        );
    end

    // frequency verdicts
    logic meas_valid;
    logic meas_fast;

    fml_freq_meter #(
        .WIN  (WIN),
        .CNT_W(CNT_W)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (restart),
        .ref_tick  (ch_tick[0]),
        .osc_tick  (ch_tick[1]),
        .meas_valid(meas_valid),
        .meas_fast (meas_fast)
    );

    // acquisition state machine
    fml_state_e        state_q, state_d;
    fml_dir_e          dir_q, dir_d, meas_dir;
    logic [CODE_W-1:0] code_q, code_d, code_up, code_dn, code_step;
    logic [ALT_W-1:0]  alt_q, alt_d;

    always_comb begin
        meas_dir  = meas_fast ? DIR_FAST : DIR_SLOW;
        code_up   = (code_q == CODE_TOP) ? code_q : code_q + 1'b1;
        code_dn   = (code_q == '0) ? code_q : code_q - 1'b1;
        code_step = meas_fast ? code_dn : code_up;
    end

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        dir_d   = dir_q;
        alt_d   = alt_q;
        if (meas_valid) begin
            unique case (state_q)
                ST_SWEEP: begin
                    code_d = code_step;
                    dir_d  = meas_dir;
                    if (!meas_fast) begin
                        // reversal: first slow verdict
                        state_d = ST_COARSE;
                        alt_d   = '0;
                    end
                end
                ST_COARSE: begin
                    code_d = code_step;
                    dir_d  = meas_dir;
                    if (meas_dir != dir_q) begin
                        if (alt_q == ALT_LAST) begin
                            state_d = ST_LOCK;
                            alt_d   = '0;
                        end else begin
                            alt_d = alt_q + 1'b1;
                        end
                    end else begin
                        alt_d = '0;
                    end
                end
                ST_LOCK: begin
                    code_d = code_step;
                    dir_d  = meas_dir;
                    if (meas_dir == dir_q) begin
                        state_d = ST_COARSE;
                        alt_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_SWEEP;
                    code_d  = CODE_TOP;
                    alt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP;
            code_q  <= CODE_TOP;
            dir_q   <= DIR_SLOW;
            alt_q   <= '0;
        end else if (restart) begin
            state_q <= ST_SWEEP;
            code_q  <= CODE_TOP;
            dir_q   <= DIR_SLOW;
            alt_q   <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            dir_q   <= dir_d;
            alt_q   <= alt_d;
        end
    end

    // outputs
    always_comb begin
        code_o = code_q;
        acq_o  = (state_q != ST_SWEEP);
        lock_o = (state_q == ST_LOCK);
    end

    // phase requests once frequency is roughly aligned
    fml_phase_det u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (acq_o),
        .ref_tick(ch_tick[0]),
        .osc_tick(ch_tick[1]),
        .adv     (adv_o),
        .rec     (rec_o)
    );

endmodule

// File: rtl/fml_loop_ctrl_chk.sv
module fml_loop_ctrl_chk #(
    parameter int CODE_W   = 4,
    parameter int CODE_MAX = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              meas_valid,
    input logic [CODE_W-1:0] code_o,
    input logic              acq_o,
    input logic              lock_o,
    input logic              adv_o,
    input logic              rec_o
);

    assert_restart_fastest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (code_o == CODE_W'(CODE_MAX) && !acq_o && !lock_o));

    assert_code_moves_on_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> ($past(meas_valid) || $past(restart)));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(code_o) && !$past(restart)) |->
        ((int'(code_o) - int'($past(code_o)) == 1) || (int'($past(code_o)) - int'(code_o) == 1)));

    assert_reversal_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq_o) |-> (code_o == CODE_W'(CODE_MAX) || int'(code_o) == int'($past(code_o)) + 1));

    assert_lock_on_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(meas_valid));

    assert_unlock_keeps_acq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lock_o) && !$past(restart)) |-> acq_o);

    assert_phase_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv_o && rec_o));

    assert_phase_after_acq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o || rec_o) |-> $past(acq_o));

endmodule

bind fml_loop_ctrl fml_loop_ctrl_chk #(
    .CODE_W  (CODE_W),
    .CODE_MAX(CODE_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .meas_valid(meas_valid),
    .code_o    (code_o),
    .acq_o     (acq_o),
    .lock_o    (lock_o),
    .adv_o     (adv_o),
    .rec_o     (rec_o)
);

// File: tb/fml_loop_ctrl_tb.sv
module fml_loop_ctrl_tb;

    localparam int WD_CYCLES = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_in = 1'b0;
    logic       ref_in = 1'b0;
    logic [7:0] fb_div = 8'd2;
    logic [7:0] rf_div = 8'd1;
    logic       load_i = 1'b0;
    logic [3:0] code_o;
    logic       acq_o;
    logic       lock_o;
    logic       adv_o;
    logic       rec_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int ref_half = 13;
    int osc_tmr = 0;
    int ref_tmr = 0;

    int adv_cnt = 0;
    int rec_cnt = 0;
    int both_cnt = 0;
    int stray_cnt = 0;
    bit prev_acq = 1'b0;

    fml_loop_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_in   (osc_in),
        .ref_in   (ref_in),
        .fb_div_i (fb_div),
        .ref_div_i(rf_div),
        .load_i   (load_i),
        .code_o   (code_o),
        .acq_o    (acq_o),
        .lock_o   (lock_o),
        .adv_o    (adv_o),
        .rec_o    (rec_o)
    );

    always #10 clk = ~clk;

    // oscillator model: half period 12-code system cycles (code 8 fastest)
    always @(negedge clk) begin
        if (osc_tmr >= 11 - int'(code_o)) begin
            osc_in  <= ~osc_in;
            osc_tmr <= 0;
        end else begin
            osc_tmr <= osc_tmr + 1;
        end
    end

    // reference model: half period ref_half system cycles
    always @(negedge clk) begin
        if (ref_tmr >= ref_half - 1) begin
            ref_in  <= ~ref_in;
            ref_tmr <= 0;
        end else begin
            ref_tmr <= ref_tmr + 1;
        end
    end

    // phase request monitor (R12)
    always @(negedge clk) begin
        if (rst_n) begin
            if (adv_o) adv_cnt++;
            if (rec_o) rec_cnt++;
            if (adv_o && rec_o) both_cnt++;
            if ((adv_o || rec_o) && !prev_acq) stray_cnt++;
        end
        prev_acq = acq_o;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_load();
        @(negedge clk);
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic observe_bracket(input int cycles, input int lo_exp, input int hi_exp,
                                   input string req);
        int lo = 99;
        int hi = -1;
        int drops = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (int'(code_o) < lo) lo = int'(code_o);
            if (int'(code_o) > hi) hi = int'(code_o);
            if (!lock_o) drops++;
        end
        chk(lo == lo_exp, req, "lower bracket code", lo, lo_exp);
        chk(hi == hi_exp, req, "upper bracket code", hi, hi_exp);
        chk(drops == 0, req, "cycles with lock low", drops, 0);
    endtask

    task automatic wait_lock(input int limit);
        int n = 0;
        while (!lock_o && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    // R1: reset values, N=2 M=1, reference half period 13 -> target period 13
    task automatic test_reset();
        rst_n = 1'b0;
        load_i = 1'b0;
        fb_div = 8'd2;
        rf_div = 8'd1;
        ref_half = 13;
        repeat (5) @(negedge clk);
        chk(code_o == 4'd8, "R1", "code in reset", int'(code_o), 8);
        chk(!acq_o, "R1", "acq in reset", int'(acq_o), 0);
        chk(!lock_o, "R1", "lock in reset", int'(lock_o), 0);
        chk(!adv_o && !rec_o, "R1", "phase pulses in reset", int'(adv_o) + int'(rec_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(code_o == 4'd8, "R1", "code after release", int'(code_o), 8);
    endtask

    // R2 R3 R5 R4: sweep 8,7,6,5 then reverse to 6 and dither 5/6
    task automatic test_acquire();
        int n = 0;
        int mono = 0;
        int lo = 99;
        int prev = int'(code_o);
        int changes = 0;
        while (!acq_o && n < 20000) begin
            @(negedge clk);
            n++;
            if (!acq_o) begin
                if (int'(code_o) > prev) mono++;
                if (int'(code_o) < lo) lo = int'(code_o);
            end
            prev = int'(code_o);
        end
        chk(acq_o, "R3", "acquisition reached", int'(acq_o), 1);
        chk(code_o == 4'd6, "R3", "code at reversal", int'(code_o), 6);
        chk(lo == 5, "R2", "lowest code in sweep", lo, 5);
        chk(mono == 0, "R2", "code rises in sweep", mono, 0);
        prev = int'(code_o);
        n = 0;
        while (!lock_o && n < 20000) begin
            @(negedge clk);
            n++;
            if (int'(code_o) != prev) changes++;
            prev = int'(code_o);
        end
        chk(lock_o, "R5", "lock reached", int'(lock_o), 1);
        chk(changes == 4, "R5", "code changes before lock", changes, 4);
        chk(code_o == 4'd6, "R5", "code at lock", int'(code_o), 6);
        observe_bracket(3400, 5, 6, "R4");
    endtask

    // R12: phase requests during lock, exclusive, never before acquisition
    task automatic test_phase();
        chk(adv_cnt + rec_cnt > 0, "R12", "phase pulses while locked", adv_cnt + rec_cnt, 1);
        chk(both_cnt == 0, "R12", "advance and recede together", both_cnt, 0);
        chk(stray_cnt == 0, "R12", "pulses without acquisition", stray_cnt, 0);
    endtask

    // R9: new ratios without load change nothing
    task automatic test_ignored();
        fb_div = 8'd7;
        rf_div = 8'd5;
        observe_bracket(3000, 5, 6, "R9");
    endtask

    // R6: reference slows to half period 17 -> target period 17, bracket 3/4
    task automatic test_unlock();
        int n = 0;
        ref_half = 17;
        while (lock_o && n < 6000) begin
            @(negedge clk);
            n++;
        end
        chk(!lock_o, "R6", "lock dropped", int'(lock_o), 0);
        chk(acq_o, "R6", "acq kept on unlock", int'(acq_o), 1);
        wait_lock(20000);
        chk(lock_o, "R6", "lock regained", int'(lock_o), 1);
        observe_bracket(5000, 3, 4, "R6");
    endtask

    // R8 R7: load N=3 M=2, reference half period 10 -> target period 13.33
    task automatic test_load();
        ref_half = 10;
        fb_div = 8'd3;
        rf_div = 8'd2;
        pulse_load();
        chk(code_o == 4'd8, "R8", "code after load", int'(code_o), 8);
        chk(!acq_o, "R8", "acq after load", int'(acq_o), 0);
        chk(!lock_o, "R8", "lock after load", int'(lock_o), 0);
        wait_lock(25000);
        chk(lock_o, "R7", "lock with new ratio", int'(lock_o), 1);
        observe_bracket(6000, 5, 6, "R7");
    endtask

    // R10: N=1 M=1, reference half period 40: every code is fast
    task automatic test_floor();
        int base;
        ref_half = 40;
        fb_div = 8'd1;
        rf_div = 8'd1;
        pulse_load();
        repeat (2) @(negedge clk);
        base = adv_cnt + rec_cnt;
        repeat (30000) @(negedge clk);
        chk(code_o == 4'd0, "R10", "code at floor", int'(code_o), 0);
        chk(!acq_o, "R10", "acq at floor", int'(acq_o), 0);
        chk(adv_cnt + rec_cnt == base, "R12", "pulses during sweep",
            adv_cnt + rec_cnt - base, 0);
    endtask

    // R11: reference half period 3: fastest code is still slow
    task automatic test_ceiling();
        int moved = 0;
        ref_half = 3;
        pulse_load();
        repeat (1500) begin
            @(negedge clk);
            if (code_o != 4'd8) moved++;
        end
        chk(moved == 0, "R11", "cycles away from code 8", moved, 0);
        chk(acq_o, "R11", "acq at ceiling", int'(acq_o), 1);
        chk(!lock_o, "R11", "lock at ceiling", int'(lock_o), 0);
    endtask

    initial begin
        test_reset();
        test_acquire();
        test_phase();
        test_ignored();
        test_unlock();
        test_load();
        test_floor();
        test_ceiling();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule